// File: doc/BRIEF.md
# SDRAM Auto-Refresh Scheduler

This block decides when an SDRAM controller must refresh the memory and produces the command timing for each refresh. It reads a 32-bit refresh control word. While refresh is switched on and the mode is auto refresh, it counts bus-clock cycles. When the programmed interval has elapsed it raises a refresh request toward the memory arbiter. After the arbiter grants the request, the block issues a precharge-all strobe. It then waits out the precharge time, issues an auto-refresh strobe, and waits out the row cycle time. Only after that does it release the memory by clearing its busy flag.

The interval and both delays come from encoded fields of the control word. The interval is written as an inverted 11-bit count, so a larger count gives a shorter period. The two delays are 2-bit codes that select a cycle count. The interval counter keeps running while a refresh waits for its grant or is in progress. Any expiry that falls in that time cannot be served, and the block counts it in a saturating missed-refresh counter. A pulse on the write strobe marks a new register value and restarts the interval. The reset input is asynchronous and active low, and it is expected to be released synchronously to `clk` by the reset logic that drives it.

Top module: `sdr_ref_sched`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `refresh_req`, `cmd_pre_all`, `cmd_auto_ref` and `busy` are 0 and `missed_cnt` is 0.
- R2: Refresh is active only when bit 23 of `cfg_word` is 1. When that bit is 0, `refresh_req` never rises.
- R3: Bit 22 selects the mode, and 0 means auto refresh. When bit 22 is 1 (self refresh), this block issues no request even if bit 23 is 1.
- R4: Bits 10:0 hold a count C. The interval is 2049 − C bus cycles, with the value 0x7FF giving 2 cycles. `refresh_req` rises exactly 2049 − C clock edges after the edge that captured a write. Reserved bits (31:24 and 17:11) are written as 0. The word 0x008C04F4 gives an interval of 781 cycles, a precharge time of 2 and a row cycle time of 7.
- R5: `refresh_req` stays high until a cycle in which `grant` is 1, and it falls at the next edge. If refresh stops being active while the request waits, the request is withdrawn at the next edge.
- R6: `cmd_pre_all` is high for one cycle, in the cycle after the grant. `cmd_auto_ref` is high for one cycle, exactly tRP cycles after it. Bits 21:20 select tRP: code 00 gives 2, 01 gives 3, and 10 or 11 gives 4.
- R7: `busy` falls exactly tRC cycles after the `cmd_auto_ref` cycle. Bits 19:18 select tRC: codes 00, 01, 10 and 11 give 4, 5, 6 and 7.
- R8: `busy` is high whenever the request or either strobe is high, and the two strobes are never high together.
- R9: The interval counter keeps counting while a refresh is pending or in progress. Each expiry that occurs while `busy` is high raises no new request and increments `missed_cnt`, which saturates at all ones.
- R10: A pulse on `cfg_wr` reloads the interval counter, so the next request is timed from that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | One-cycle pulse marking a new value on `cfg_word` |
| cfg_word | input | 32 | Refresh control word |
| grant | input | 1 | Arbiter grant for the pending refresh |
| refresh_req | output | 1 | Refresh request, held until granted |
| cmd_pre_all | output | 1 | One-cycle precharge-all command strobe |
| cmd_auto_ref | output | 1 | One-cycle auto-refresh command strobe |
| busy | output | 1 | Memory reserved by the refresh sequence |
| missed_cnt | output | 4 | Saturating count of expiries that could not be served |

## Verification
A wrong interval count would move the rising edge of `refresh_req` away from 2049 − C edges after a write. A cycle-by-cycle comparison catches this on the first request. A wrong delay decode or a wrong wait counter would shift `cmd_auto_ref` or the fall of `busy` by at least one cycle within one refresh sequence. A state machine that gets stuck, or one that drops a request before the grant, shows as a mismatch on `refresh_req` or `busy` in the very next cycle. The missed-refresh path is driven with the shortest interval and a slow grant. An error in the increment or in the saturation therefore shows on `missed_cnt` within a few tens of cycles.

// File: rtl/sdr_ref_pkg.sv
package sdr_ref_pkg;

  localparam int EN_BIT   = 23;
  localparam int MODE_BIT = 22;
  localparam int TRP_LO   = 20;
  localparam int TRC_LO   = 18;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_PRE,
    ST_TRP,
    ST_ARF,
    ST_TRC
  } ref_state_t;

  // precharge time in clocks for a 2-bit code
  function automatic logic [2:0] trp_clocks(input logic [1:0] code);
    case (code)
      2'b00:   trp_clocks = 3'd2;
      2'b01:   trp_clocks = 3'd3;
      default: trp_clocks = 3'd4;
    endcase
  endfunction

  // row cycle time in clocks for a 2-bit code
  function automatic logic [2:0] trc_clocks(input logic [1:0] code);
    trc_clocks = 3'd4 + {1'b0, code};
  endfunction

endpackage

// File: rtl/sdr_ref_interval.sv
module sdr_ref_interval #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic             active,
  input  logic [CNT_W-1:0] count_field,
  output logic             expire
);

  localparam int PER_W = CNT_W + 1;
  localparam logic [PER_W-1:0] BASE = PER_W'((1 << CNT_W) + 1);

  logic [PER_W-1:0] period;
  logic [PER_W-1:0] last_val;
  logic [PER_W-1:0] cnt_q;
  logic [PER_W-1:0] cnt_d;

  assign period   = BASE - {1'b0, count_field};
  assign last_val = period - PER_W'(1);
  assign expire   = active & ~cfg_wr & (cnt_q == last_val);

  always_comb begin
    cnt_d = cnt_q;
    if (cfg_wr || !active || expire) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + PER_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // R10: a register write restarts the interval
  assert_reload_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (cnt_q == '0));

endmodule

// File: rtl/sdr_ref_seq.sv
module sdr_ref_seq
  import sdr_ref_pkg::*;
#(
  parameter int DLY_W = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active,
  input  logic       expire,
  input  logic       grant,
  input  logic [1:0] trp_code,
  input  logic [1:0] trc_code,
  output logic       req,
  output logic       pre,
  output logic       arf,
  output logic       busy,
  output logic       drop
);

  ref_state_t       state_q, state_d;
  logic [DLY_W-1:0] dly_q, dly_d;
  logic [DLY_W-1:0] trp_load;
  logic [DLY_W-1:0] trc_load;

  // wait states last (delay - 1) cycles after the one-cycle strobe
  assign trp_load = DLY_W'(trp_clocks(trp_code)) - DLY_W'(2);
  assign trc_load = DLY_W'(trc_clocks(trc_code)) - DLY_W'(2);

  always_comb begin
    state_d = state_q;
    dly_d   = dly_q;
    case (state_q)
      ST_IDLE: if (expire) state_d = ST_REQ;
      ST_REQ: begin
        if (!active)    state_d = ST_IDLE;
        else if (grant) state_d = ST_PRE;
      end
      ST_PRE: begin
        state_d = ST_TRP;
        dly_d   = trp_load;
      end
      ST_TRP: begin
        if (dly_q == '0) state_d = ST_ARF;
        else             dly_d   = dly_q - DLY_W'(1);
      end
      ST_ARF: begin
        state_d = ST_TRC;
        dly_d   = trc_load;
      end
      ST_TRC: begin
        if (dly_q == '0) state_d = ST_IDLE;
        else             dly_d   = dly_q - DLY_W'(1);
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      dly_q   <= '0;
    end else begin
      state_q <= state_d;
      dly_q   <= dly_d;
    end
  end

  assign req  = (state_q == ST_REQ);
  assign pre  = (state_q == ST_PRE);
  assign arf  = (state_q == ST_ARF);
  assign busy = (state_q != ST_IDLE);
  assign drop = expire & busy;

  assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(pre && arf));

  assert_busy_cover_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req || pre || arf) |-> busy);

  assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !grant && active) |=> req);

  assert_pre_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pre |=> (!arf && busy));

endmodule

// File: rtl/sdr_ref_miss.sv
module sdr_ref_miss #(
  parameter int MISS_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc,
  output logic [MISS_W-1:0] count
);

  logic [MISS_W-1:0] cnt_q, cnt_d;
  logic              at_max;

  assign at_max = &cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (inc && !at_max) cnt_d = cnt_q + MISS_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign count = cnt_q;

  assert_miss_sat_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (&count) |=> (&count));

  assert_miss_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((count == $past(count)) || (count == $past(count) + MISS_W'(1))));

endmodule

// File: rtl/sdr_ref_sched.sv
module sdr_ref_sched
  import sdr_ref_pkg::*;
#(
  parameter int REG_W  = 32,
  parameter int CNT_W  = 11,
  parameter int DLY_W  = 3,
  parameter int MISS_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [REG_W-1:0]  cfg_word,
  input  logic              grant,
  output logic              refresh_req,
  output logic              cmd_pre_all,
  output logic              cmd_auto_ref,
  output logic              busy,
  output logic [MISS_W-1:0] missed_cnt
);

  logic active;
  logic expire;
  logic drop;

  // auto refresh only: enabled and mode bit clear
  assign active = cfg_word[EN_BIT] & ~cfg_word[MODE_BIT];

  sdr_ref_interval #(.CNT_W(CNT_W)) u_interval (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr     (cfg_wr),
    .active     (active),
    .count_field(cfg_word[CNT_W-1:0]),
    .expire     (expire)
  );

  sdr_ref_seq #(.DLY_W(DLY_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (active),
    .expire  (expire),
    .grant   (grant),
    .trp_code(cfg_word[TRP_LO+1:TRP_LO]),
    .trc_code(cfg_word[TRC_LO+1:TRC_LO]),
    .req     (refresh_req),
    .pre     (cmd_pre_all),
    .arf     (cmd_auto_ref),
    .busy    (busy),
    .drop    (drop)
  );

  sdr_ref_miss #(.MISS_W(MISS_W)) u_miss (
    .clk  (clk),
    .rst_n(rst_n),
    .inc  (drop),
    .count(missed_cnt)
  );

  // R2 and R3: no request can start while refresh is off or in self-refresh mode
  assert_off_no_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !refresh_req) |=> !refresh_req);

  // R4: reserved fields are written as zero
  assert_rsvd_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |-> ((cfg_word[REG_W-1:EN_BIT+1] == '0) &&
                (cfg_word[TRC_LO-1:CNT_W] == '0)));

endmodule

// File: tb/sdr_ref_sched_tb.sv
module sdr_ref_sched_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [31:0] cfg_word = 32'h0;
  logic        grant = 1'b0;
  logic        refresh_req, cmd_pre_all, cmd_auto_ref, busy;
  logic [3:0]  missed_cnt;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int grant_delay = 0;
  int gwait = 0;
  bit done = 1'b0;

  // behavioural reference state
  int m_ph = 0;
  int m_rem = 0;
  int m_cnt = 0;
  int m_miss = 0;

  always #5 clk = ~clk;

  sdr_ref_sched u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_word(cfg_word),
    .grant(grant), .refresh_req(refresh_req), .cmd_pre_all(cmd_pre_all),
    .cmd_auto_ref(cmd_auto_ref), .busy(busy), .missed_cnt(missed_cnt)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // reference model, advanced on every rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_rem = 0; m_cnt = 0; m_miss = 0;
    end else begin
      int period, trp, trc, tc, rc;
      bit act, exp_now;
      act     = cfg_word[23] && !cfg_word[22];
      period  = 2049 - int'(cfg_word[10:0]);
      tc      = int'(cfg_word[21:20]);
      rc      = int'(cfg_word[19:18]);
      trp     = (tc < 2) ? tc + 2 : 4;
      trc     = 4 + rc;
      exp_now = act && !cfg_wr && (m_cnt == period - 1);
      if (exp_now && m_ph != 0 && m_miss < 15) m_miss++;
      if (cfg_wr || !act || exp_now) m_cnt = 0; else m_cnt++;
      case (m_ph)
        0: if (exp_now) m_ph = 1;
        1: if (!act) m_ph = 0; else if (grant) m_ph = 2;
        2: begin m_ph = 3; m_rem = trp - 1; end
        3: begin m_rem--; if (m_rem == 0) m_ph = 4; end
        4: begin m_ph = 5; m_rem = trc - 1; end
        default: begin m_rem--; if (m_rem == 0) m_ph = 0; end
      endcase
    end
  end

  // per-cycle comparison and grant responder, away from the rising edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n && !done) begin
      check(refresh_req == (m_ph == 1), "R5 refresh_req", refresh_req, m_ph == 1);
      check(cmd_pre_all == (m_ph == 2), "R6 cmd_pre_all", cmd_pre_all, m_ph == 2);
      check(cmd_auto_ref == (m_ph == 4), "R6 cmd_auto_ref", cmd_auto_ref, m_ph == 4);
      check(busy == (m_ph != 0), "R7 busy", busy, m_ph != 0);
      check(int'(missed_cnt) == m_miss, "R9 missed_cnt", missed_cnt, m_miss);
    end
    if (refresh_req) begin
      grant <= (gwait >= grant_delay);
      gwait++;
    end else begin
      grant <= 1'b0;
      gwait = 0;
    end
  end

  task automatic write_cfg(input logic [31:0] v);
    @(negedge clk);
    cfg_word = v;
    cfg_wr   = 1'b1;
    @(negedge clk);
    cfg_wr   = 1'b0;
  endtask

  task automatic wait_req(output int n);
    n = 0;
    while (!refresh_req && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  // measure strobe spacing of one sequence once it has been granted
  task automatic measure_seq(output int d_trp, output int d_trc);
    int t;
    t = 0;
    while (!cmd_pre_all && t < 5000) begin @(negedge clk); t++; end
    d_trp = 0;
    while (!cmd_auto_ref && d_trp < 100) begin @(negedge clk); d_trp++; end
    d_trc = 0;
    while (busy && d_trc < 100) begin @(negedge clk); d_trc++; end
  endtask

  initial begin
    int n, a, b, seen;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!refresh_req && !cmd_pre_all && !cmd_auto_ref && !busy, "R1 outputs in reset",
          {refresh_req, cmd_pre_all, cmd_auto_ref, busy}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && missed_cnt == 0, "R1 state after reset", {busy, missed_cnt}, 0);

    // R2: enable bit clear, no request
    write_cfg(32'h0000_04F4);
    seen = 0;
    for (int i = 0; i < 1000; i++) begin @(negedge clk); if (refresh_req) seen = 1; end
    check(seen == 0, "R2 no request when disabled", seen, 0);

    // R3: self-refresh mode ignored
    write_cfg(32'h00C0_07F0);
    seen = 0;
    for (int i = 0; i < 100; i++) begin @(negedge clk); if (refresh_req) seen = 1; end
    check(seen == 0, "R3 no request in self-refresh mode", seen, 0);

    // R4, R6, R7: period 17, tRP code 01 -> 3, tRC code 10 -> 6, slow grant
    grant_delay = 3;
    write_cfg(32'h0098_07F0);
    wait_req(n);
    check(n == 17, "R4 interval 17", n, 17);
    measure_seq(a, b);
    check(a == 3, "R6 tRP code 01", a, 3);
    check(b == 6, "R7 tRC code 10", b, 6);

    // R4, R6, R7: the reference word
    grant_delay = 0;
    write_cfg(32'h008C_04F4);
    wait_req(n);
    check(n == 781, "R4 interval 781", n, 781);
    measure_seq(a, b);
    check(a == 2, "R6 tRP code 00", a, 2);
    check(b == 7, "R7 tRC code 11", b, 7);

    // R10: rewrite restarts the interval
    write_cfg(32'h0080_07F0);
    repeat (10) @(negedge clk);
    write_cfg(32'h0080_07F0);
    wait_req(n);
    check(n == 17, "R10 reload on write", n, 17);
    repeat (20) @(negedge clk);

    // R5: request withdrawn when refresh switched off while waiting
    grant_delay = 100000;
    write_cfg(32'h0080_07F0);
    wait_req(n);
    write_cfg(32'h0000_07F0);
    check(!refresh_req && !busy, "R5 withdraw on disable", {refresh_req, busy}, 0);
    repeat (5) @(negedge clk);

    // R9: shortest interval with a slow grant overruns and saturates
    grant_delay = 40;
    write_cfg(32'h0080_07FF);
    repeat (150) @(negedge clk);
    check(missed_cnt == 4'hF, "R9 miss counter saturates", missed_cnt, 15);
    // R8: busy covers the strobes through a sequence
    seen = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if ((cmd_pre_all || cmd_auto_ref || refresh_req) && !busy) seen = 1;
      if (cmd_pre_all && cmd_auto_ref) seen = 1;
    end
    check(seen == 0, "R8 strobes inside busy", seen, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule